// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a two-part logical address (a segment number and an offset inside that segment) into a physical address. It does so against a small on-chip segment table. Software fills each table slot through a write port. A slot carries a physical base, a length (limit), a valid flag, three access rights (read, write, execute), and two status flags: referenced and modified. A separate length register says how many segment numbers are legal.

Each request is accepted with a valid/ready handshake. The block checks, in a fixed priority, the segment number, the slot's valid flag, the offset against the limit, and the access rights. One cycle after acceptance it returns either the physical address (base plus offset) or a fault cause. A successful access marks the slot as referenced, and a successful write also marks it as modified. A status port reads back those two flags for any slot.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and for three clock edges after it is released, `req_ready` and `rsp_valid` are 0. Reset leaves the length register at 0 and every slot with valid, rights, referenced and modified flags at 0. The first request after reset therefore faults with code 1.
- R2: A request accepted (req_valid and req_ready both 1) at a clock edge gives `rsp_valid`=1 for exactly the following cycle. A cycle with no accepted request gives `rsp_valid`=0 in the next cycle. When there is no fault, `rsp_paddr` = (base + offset) modulo 2^PA_W and `rsp_fault`=0.
- R3: If the segment number is greater than or equal to the length register, the request faults with code 1.
- R4: If the slot's valid flag is 0, the request faults with code 2.
- R5: If the offset is greater than or equal to the slot's limit, the request faults with code 3. An offset of limit-1 passes this check.
- R6: Access codes on `req_acc` are 0 read, 1 write, 2 execute and 3 reserved. Rights bits in `tbl_perm` are bit 0 read, bit 1 write and bit 2 execute. An access whose right bit is 0, or any reserved access, faults with code 4.
- R7: A request with no fault sets the slot's referenced flag. A write with no fault also sets its modified flag. A faulted request changes neither flag. Both flags are visible on `st_ref`/`st_mod` from the edge that accepted the request.
- R8: A faulted response carries `rsp_paddr`=0.
- R9: A table write or length write in the same cycle as a request is applied before that request is checked. If a status update lands on a slot that software writes in the same cycle, the update is applied on top of the written flags.
- R10: When several faults apply at once, the lowest code is reported, in the order 1, 2, 3, 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table slot write strobe |
| tbl_idx | input | SEG_W | Slot being written |
| tbl_base | input | PA_W | Physical base for the slot |
| tbl_limit | input | OFF_W+1 | Segment length |
| tbl_valid | input | 1 | Valid flag for the slot |
| tbl_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| tbl_ref | input | 1 | Initial referenced flag |
| tbl_mod | input | 1 | Initial modified flag |
| len_we | input | 1 | Length register write strobe |
| len_val | input | SEG_W+1 | Number of legal segments |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block accepts requests |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset inside the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 3 | Fault cause code |
| st_idx | input | SEG_W | Slot whose status flags are shown |
| st_ref | output | 1 | Referenced flag of slot st_idx |
| st_mod | output | 1 | Modified flag of slot st_idx |

## Verification
The hardest case to reach from the ports is a table write, a length write and a lookup that all hit the same slot at the same edge, while the lookup also succeeds and so writes status back into the slot being rewritten. The bench builds this case on purpose. It rewrites a slot and grows the length register in the same cycle as a request to that slot, then reads the slot's flags back through the status port. A long stretch of random writes, length changes and requests of every access kind then follows, all compared with a behavioural model on every clock. That stretch covers the overlaps of several fault causes for the priority rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SEG  = 3'd1,
    FLT_INV  = 3'd2,
    FLT_LIM  = 3'd3,
    FLT_PERM = 3'd4
  } flt_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_W  = 3;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int N_SEG = 16,
  parameter int SEG_W = 4,
  parameter int PA_W  = 20,
  parameter int LIM_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              wr_ref,
  input  logic              wr_mod,
  input  logic [SEG_W-1:0]  lk_idx,
  output logic [PA_W-1:0]   lk_base,
  output logic [LIM_W-1:0]  lk_limit,
  output logic              lk_valid,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              upd_en,
  input  logic [SEG_W-1:0]  upd_idx,
  input  logic              upd_mod,
  input  logic [SEG_W-1:0]  st_idx,
  output logic              st_ref,
  output logic              st_mod
);

  logic [PA_W-1:0]   base_q  [N_SEG];
  logic [PA_W-1:0]   base_d  [N_SEG];
  logic [LIM_W-1:0]  lim_q   [N_SEG];
  logic [LIM_W-1:0]  lim_d   [N_SEG];
  logic [PERM_W-1:0] perm_q  [N_SEG];
  logic [PERM_W-1:0] perm_d  [N_SEG];
  logic [N_SEG-1:0]  valid_q, valid_d;
  logic [N_SEG-1:0]  ref_q,   ref_d;
  logic [N_SEG-1:0]  mod_q,   mod_d;
  logic [N_SEG-1:0]  wr_hit, upd_hit, ent_ce;

  // per-slot decode of the two update sources
  for (genvar g = 0; g < N_SEG; g++) begin : g_hit
    assign wr_hit[g]  = wr_en  && (wr_idx  == SEG_W'(g));
    assign upd_hit[g] = upd_en && (upd_idx == SEG_W'(g));
    assign ent_ce[g]  = wr_hit[g] || upd_hit[g];
  end

  // next state: software load first, status merge on top
  always_comb begin
    for (int i = 0; i < N_SEG; i++) begin
      base_d[i]  = base_q[i];
      lim_d[i]   = lim_q[i];
      perm_d[i]  = perm_q[i];
      valid_d[i] = valid_q[i];
      ref_d[i]   = ref_q[i];
      mod_d[i]   = mod_q[i];
      if (wr_hit[i]) begin
        base_d[i]  = wr_base;
        lim_d[i]   = wr_limit;
        perm_d[i]  = wr_perm;
        valid_d[i] = wr_valid;
        ref_d[i]   = wr_ref;
        mod_d[i]   = wr_mod;
      end
      if (upd_hit[i]) begin
        ref_d[i] = 1'b1;
        if (upd_mod) begin
          mod_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        perm_q[i] <= '0;
      end
      valid_q <= '0;
      ref_q   <= '0;
      mod_q   <= '0;
    end else begin
      for (int i = 0; i < N_SEG; i++) begin
        if (ent_ce[i]) begin
          base_q[i]  <= base_d[i];
          lim_q[i]   <= lim_d[i];
          perm_q[i]  <= perm_d[i];
          valid_q[i] <= valid_d[i];
          ref_q[i]   <= ref_d[i];
          mod_q[i]   <= mod_d[i];
        end
      end
    end
  end

  // lookup sees a same-cycle software write (R9)
  logic lk_fwd;
  assign lk_fwd   = wr_en && (wr_idx == lk_idx);
  assign lk_base  = lk_fwd ? wr_base  : base_q[lk_idx];
  assign lk_limit = lk_fwd ? wr_limit : lim_q[lk_idx];
  assign lk_valid = lk_fwd ? wr_valid : valid_q[lk_idx];
  assign lk_perm  = lk_fwd ? wr_perm  : perm_q[lk_idx];

  assign st_ref = ref_q[st_idx];
  assign st_mod = mod_q[st_idx];

  // R7: a status update always leaves the flag set in the slot it names
  a_r7_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> ref_q[$past(upd_idx)]);

  a_r7_mod_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_mod) |=> mod_q[$past(upd_idx)]);

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20,
  parameter int LEN_W = 5,
  parameter int LIM_W = 13
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  acc_e              acc,
  input  logic [PA_W-1:0]   base,
  input  logic [LIM_W-1:0]  limit,
  input  logic              valid,
  input  logic [PERM_W-1:0] perm,
  output flt_e              fault,
  output logic [PA_W-1:0]   paddr
);

  logic seg_bad, lim_bad, perm_ok;

  assign seg_bad = (LEN_W'(seg) >= len);
  assign lim_bad = (LIM_W'(off) >= limit);

  always_comb begin
    unique case (acc)
      ACC_RD:  perm_ok = perm[PERM_RD];
      ACC_WR:  perm_ok = perm[PERM_WR];
      ACC_EX:  perm_ok = perm[PERM_EX];
      default: perm_ok = 1'b0;
    endcase
  end

  // fixed priority of causes (R10)
  always_comb begin
    if (seg_bad) begin
      fault = FLT_SEG;
    end else if (!valid) begin
      fault = FLT_INV;
    end else if (lim_bad) begin
      fault = FLT_LIM;
    end else if (!perm_ok) begin
      fault = FLT_PERM;
    end else begin
      fault = FLT_NONE;
    end
  end

  assign paddr = (fault == FLT_NONE) ? (base + PA_W'(off)) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int N_SEG = 16,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20,
  localparam int SEG_W = $clog2(N_SEG),
  localparam int LEN_W = SEG_W + 1,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [LIM_W-1:0] tbl_limit,
  input  logic             tbl_valid,
  input  logic [2:0]       tbl_perm,
  input  logic             tbl_ref,
  input  logic             tbl_mod,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_fault,
  input  logic [SEG_W-1:0] st_idx,
  output logic             st_ref,
  output logic             st_mod
);

  logic rst_int_n;

  seg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  // acceptance
  logic ready_q, fire;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;

  // length register, forwarded to a same-cycle lookup
  logic [LEN_W-1:0] len_q, len_eff;

  assign len_eff = len_we ? len_val : len_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= len_val;
    end
  end

  // table and checks
  logic [PA_W-1:0]   lk_base;
  logic [LIM_W-1:0]  lk_limit;
  logic              lk_valid;
  logic [PERM_W-1:0] lk_perm;
  flt_e              chk_fault;
  logic [PA_W-1:0]   chk_paddr;
  acc_e              acc;
  logic              upd_en, upd_mod;

  assign acc     = acc_e'(req_acc);
  assign upd_en  = fire && (chk_fault == FLT_NONE);
  assign upd_mod = (acc == ACC_WR);

  seg_table #(
    .N_SEG (N_SEG),
    .SEG_W (SEG_W),
    .PA_W  (PA_W),
    .LIM_W (LIM_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_base  (tbl_base),
    .wr_limit (tbl_limit),
    .wr_valid (tbl_valid),
    .wr_perm  (tbl_perm),
    .wr_ref   (tbl_ref),
    .wr_mod   (tbl_mod),
    .lk_idx   (req_seg),
    .lk_base  (lk_base),
    .lk_limit (lk_limit),
    .lk_valid (lk_valid),
    .lk_perm  (lk_perm),
    .upd_en   (upd_en),
    .upd_idx  (req_seg),
    .upd_mod  (upd_mod),
    .st_idx   (st_idx),
    .st_ref   (st_ref),
    .st_mod   (st_mod)
  );

  seg_check #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W),
    .LEN_W (LEN_W),
    .LIM_W (LIM_W)
  ) u_check (
    .len   (len_eff),
    .seg   (req_seg),
    .off   (req_off),
    .acc   (acc),
    .base  (lk_base),
    .limit (lk_limit),
    .valid (lk_valid),
    .perm  (lk_perm),
    .fault (chk_fault),
    .paddr (chk_paddr)
  );

  // response register
  logic            rsp_valid_q, rsp_valid_d;
  logic [PA_W-1:0] rsp_paddr_q, rsp_paddr_d;
  logic [2:0]      rsp_fault_q, rsp_fault_d;

  always_comb begin
    rsp_valid_d = fire;
    rsp_paddr_d = rsp_paddr_q;
    rsp_fault_d = rsp_fault_q;
    if (fire) begin
      rsp_paddr_d = chk_paddr;
      rsp_fault_d = chk_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_paddr_q <= rsp_paddr_d;
      rsp_fault_q <= rsp_fault_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_paddr = rsp_paddr_q;
  assign rsp_fault = rsp_fault_q;

  // R2: one response per accepted request, none otherwise
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    fire |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fire |=> !rsp_valid);

  // R3: out-of-range segment number always reports code 1
  a_r3_seg_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire && (LEN_W'(req_seg) >= len_eff)) |=> (rsp_fault == 3'd1));

  // R8: a faulted response carries no address
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && (rsp_fault != 3'd0)) |-> (rsp_paddr == '0));

  // R1: nothing is accepted before the block is ready
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_ready |=> !rsp_valid);

endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;

  localparam int N_SEG = 16;
  localparam int OFF_W = 12;
  localparam int PA_W  = 20;
  localparam int SEG_W = 4;
  localparam int LEN_W = 5;
  localparam int LIM_W = 13;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tbl_we, tbl_valid, tbl_ref, tbl_mod;
  logic [SEG_W-1:0] tbl_idx;
  logic [PA_W-1:0]  tbl_base;
  logic [LIM_W-1:0] tbl_limit;
  logic [2:0]       tbl_perm;
  logic             len_we;
  logic [LEN_W-1:0] len_val;
  logic             req_valid, req_ready;
  logic [SEG_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  logic [1:0]       req_acc;
  logic             rsp_valid;
  logic [PA_W-1:0]  rsp_paddr;
  logic [2:0]       rsp_fault;
  logic [SEG_W-1:0] st_idx;
  logic             st_ref, st_mod;

  always #10 clk = ~clk;

  seg_xlate #(.N_SEG(N_SEG), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .tbl_valid(tbl_valid), .tbl_perm(tbl_perm), .tbl_ref(tbl_ref), .tbl_mod(tbl_mod),
    .len_we(len_we), .len_val(len_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .st_idx(st_idx), .st_ref(st_ref), .st_mod(st_mod)
  );

  // behavioural model
  int m_base [N_SEG];
  int m_lim  [N_SEG];
  int m_perm [N_SEG];
  bit m_val  [N_SEG];
  bit m_ref  [N_SEG];
  bit m_mod  [N_SEG];
  int m_len;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model applies writes, then the lookup; compare after the edge
  task automatic step(string tag);
    bit e_v;
    int e_flt, e_pa;
    bit ok_perm;
    if (tbl_we) begin
      m_base[tbl_idx] = int'(tbl_base);
      m_lim[tbl_idx]  = int'(tbl_limit);
      m_perm[tbl_idx] = int'(tbl_perm);
      m_val[tbl_idx]  = tbl_valid;
      m_ref[tbl_idx]  = tbl_ref;
      m_mod[tbl_idx]  = tbl_mod;
    end
    if (len_we) m_len = int'(len_val);
    e_v = req_valid && req_ready;
    e_flt = 0;
    e_pa = 0;
    if (e_v) begin
      case (req_acc)
        2'd0: ok_perm = m_perm[req_seg][0];
        2'd1: ok_perm = m_perm[req_seg][1];
        2'd2: ok_perm = m_perm[req_seg][2];
        default: ok_perm = 0;
      endcase
      if (int'(req_seg) >= m_len) e_flt = 1;
      else if (!m_val[req_seg]) e_flt = 2;
      else if (int'(req_off) >= m_lim[req_seg]) e_flt = 3;
      else if (!ok_perm) e_flt = 4;
      if (e_flt == 0) begin
        e_pa = (m_base[req_seg] + int'(req_off)) & 32'hFFFFF;
        m_ref[req_seg] = 1;
        if (req_acc == 2'd1) m_mod[req_seg] = 1;
      end
    end
    @(posedge clk);
    #2;
    check(rsp_valid === e_v, {tag, " rsp_valid"}, int'(rsp_valid), int'(e_v));
    if (e_v) begin
      check(rsp_fault === 3'(e_flt), {tag, " fault"}, int'(rsp_fault), e_flt);
      check(rsp_paddr === 20'(e_pa), {tag, " paddr"}, int'(rsp_paddr), e_pa);
    end
    tbl_we = 0;
    len_we = 0;
    req_valid = 0;
  endtask

  task automatic chk_stat(int idx, string tag);
    st_idx = SEG_W'(idx);
    #1;
    check(st_ref === m_ref[idx], {tag, " st_ref"}, int'(st_ref), int'(m_ref[idx]));
    check(st_mod === m_mod[idx], {tag, " st_mod"}, int'(st_mod), int'(m_mod[idx]));
  endtask

  task automatic set_ent(int idx, int base, int lim, bit v, int perm);
    tbl_we = 1; tbl_idx = SEG_W'(idx); tbl_base = PA_W'(base);
    tbl_limit = LIM_W'(lim); tbl_valid = v; tbl_perm = 3'(perm);
    tbl_ref = 0; tbl_mod = 0;
  endtask

  task automatic set_req(int seg, int off, int acc);
    req_valid = 1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
  endtask

  task automatic set_len(int n);
    len_we = 1; len_val = LEN_W'(n);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_SEG; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0;
      m_val[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    m_len = 0;
    rst_n = 0;
    tbl_we = 0; tbl_idx = 0; tbl_base = 0; tbl_limit = 0; tbl_valid = 0;
    tbl_perm = 0; tbl_ref = 0; tbl_mod = 0;
    len_we = 0; len_val = 0;
    req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0; st_idx = 0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check(req_ready === 1'b0, "R1 ready in reset", int'(req_ready), 0);
    check(rsp_valid === 1'b0, "R1 rsp in reset", int'(rsp_valid), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(req_ready === 1'b0, "R1 ready after release", int'(req_ready), 0);
    repeat (4) step("R1 idle");
    check(req_ready === 1'b1, "R1 ready up", int'(req_ready), 1);
    set_req(0, 0, 0); step("R1 empty table");
    chk_stat(0, "R1");

    // populate
    set_len(4);  step("R9 len");
    set_ent(0, 'h10000, 'h100, 1, 3); step("R2 load0");
    set_ent(1, 'hFFF00, 'h1000, 1, 4); step("R2 load1");
    set_ent(2, 'h500, 'h100, 0, 7); step("R4 load2");
    set_ent(3, 'h200, 0, 1, 7); step("R5 load3");

    set_req(0, 'h10, 0);  step("R2 read");
    chk_stat(0, "R7 ref only");
    set_req(0, 'hFF, 1);  step("R5 last offset write");
    chk_stat(0, "R7 mod set");
    set_req(0, 'h100, 0); step("R5 at limit");
    set_req(1, 'h200, 2); step("R2 wrap");
    set_req(1, 'h200, 0); step("R6 read denied");
    set_req(1, 'h200, 1); step("R6 write denied");
    set_req(0, 'h1, 3);   step("R6 reserved");
    set_req(2, 0, 0);     step("R4 invalid");
    chk_stat(2, "R7 no ref on fault");
    set_req(5, 0, 0);     step("R3 beyond len");
    set_req(15, 0, 0);    step("R3 top seg");
    set_req(3, 0, 0);     step("R5 zero limit");
    set_len(2); step("R10 shrink");
    set_req(2, 0, 0);     step("R10 seg before invalid");
    set_len(5); step("R10 grow");
    set_ent(4, 'h4000, 'h10, 1, 0); step("R10 load4");
    set_req(4, 'h20, 0);  step("R10 limit before perm");
    set_req(4, 'h5, 0);   step("R6 no rights");
    chk_stat(4, "R7 faults leave flags");
    set_req(4, 'h20, 0); set_len(4); step("R10 seg before limit");

    // R9: same-cycle writes ahead of lookup
    set_ent(5, 'h300, 'h40, 1, 1); set_len(6); set_req(5, 3, 0); step("R9 fwd hit");
    chk_stat(5, "R9 merged ref");
    set_ent(0, 'h10000, 'h100, 0, 3); set_req(0, 1, 0); step("R9 fwd invalid");
    set_ent(5, 'h300, 'h40, 1, 2); tbl_mod = 1; set_req(5, 3, 1); step("R9 fwd perm");
    chk_stat(5, "R9 rewrite flags");
    set_req(1, 0, 2); step("R2 back1");
    set_req(1, 1, 2); step("R2 back2");
    step("R2 idle");

    // random stretch
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        set_ent($urandom_range(0, 15), $urandom, $urandom_range(0, 4096),
                $urandom_range(0, 3) != 0, $urandom_range(0, 7));
        tbl_ref = 1'($urandom); tbl_mod = 1'($urandom);
      end
      if ($urandom_range(0, 7) == 0) set_len($urandom_range(0, 16));
      if ($urandom_range(0, 3) != 0)
        set_req($urandom_range(0, 15), $urandom_range(0, 4095), $urandom_range(0, 3));
      step("R10 random");
      if ((n % 16) == 0) chk_stat($urandom_range(0, 15), "R7 random");
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule